// File: doc/BRIEF.md
# Power-Management Command Port with SMI Doorbell

This block is a pair of byte-wide registers on a small I/O port. Address bit 0 picks the register: 0 is the command byte and 1 is the scratch status byte. Software can write either byte and read it back.

A write to the command byte has two side effects:
- Two reserved values are mode-switch commands. They raise a one-cycle strobe that sets or clears the SCI-enable flag held in the power-management control register outside this block.
- Any command-byte write acts as a doorbell. It raises a one-cycle system-management interrupt pulse, but only when bit 1 of the external SMI configuration byte is set.

Writes to the status byte only store data and have no side effects.

Top module: `apm_cmd_port`

## Requirements
- R1: After reset both bytes read 0x00, and `sci_set`, `sci_clr` and `smi_pulse` are low.
- R2: A write with `addr`=0 stores `wr_data` in the command byte. The read data for `addr`=0 returns it from the cycle after the write edge.
- R3: A write with `addr`=1 stores `wr_data` in the status byte. The read data for `addr`=1 returns it. The status byte and the command byte do not affect each other.
- R4: Writing 0xF1 to the command byte makes `sci_set` high for exactly the one cycle after the write edge.
- R5: Writing 0xF0 to the command byte makes `sci_clr` high for exactly the one cycle after the write edge.
- R6: Writing any value other than 0xF0 or 0xF1 to the command byte stores it and leaves both `sci_set` and `sci_clr` low.
- R7: A command-byte write makes `smi_pulse` high for the one cycle after the write edge if `smi_cfg[1]` is 1. It leaves `smi_pulse` low if `smi_cfg[1]` is 0, whatever the other configuration bits are.
- R8: A status-byte write never raises `smi_pulse`, `sci_set` or `sci_clr`, even when it carries 0xF0 or 0xF1.
- R9: `sci_set` and `sci_clr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | 1 | Register select: 0 = command, 1 = status |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the byte selected by `addr` |
| smi_cfg | input | 8 | SMI configuration byte; bit 1 enables the doorbell |
| sci_set | output | 1 | One-cycle strobe: set the SCI-enable flag |
| sci_clr | output | 1 | One-cycle strobe: clear the SCI-enable flag |
| smi_pulse | output | 1 | One-cycle system-management interrupt pulse |

## Verification
A single command-byte write of 0xF1 with `smi_cfg[1]` set must raise both the SCI-set strobe and the SMI doorbell. Both must appear in the same cycle after the write edge. The bench provokes this collision from its vector table. It checks that both outputs are high together in that cycle and that both are low one cycle later. It also writes 0xF1 and then 0xF0 on consecutive cycles to show that the set and clear strobes follow each other without overlapping.

// File: rtl/apm_cmd_port.sv
module apm_cmd_port #(
  parameter int          DW      = 8,
  parameter logic [7:0]  CMD_ON  = 8'hF1,
  parameter logic [7:0]  CMD_OFF = 8'hF0,
  parameter int          SMI_BIT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [7:0]    smi_cfg,
  output logic          sci_set,
  output logic          sci_clr,
  output logic          smi_pulse
);

  logic [DW-1:0] cmd_q, stat_q;
  logic          cmd_wr, stat_wr;

  assign cmd_wr  = wr_en && !addr;
  assign stat_wr = wr_en &&  addr;
  assign rd_data = addr ? stat_q : cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      stat_q    <= '0;
      sci_set   <= 1'b0;
      sci_clr   <= 1'b0;
      smi_pulse <= 1'b0;
    end else begin
      if (cmd_wr)  cmd_q  <= wr_data;
      if (stat_wr) stat_q <= wr_data;
      sci_set   <= cmd_wr && (wr_data == DW'(CMD_ON));
      sci_clr   <= cmd_wr && (wr_data == DW'(CMD_OFF));
      smi_pulse <= cmd_wr && smi_cfg[SMI_BIT];
    end
  end

  // R9
  sci_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sci_set && sci_clr));

  // R4
  sci_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wr_data == DW'(CMD_ON)) |=> sci_set);

  // R5
  sci_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wr_data == DW'(CMD_OFF)) |=> sci_clr);

  // R7
  smi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !addr && smi_cfg[SMI_BIT]) |=> !smi_pulse);

  // R8
  stat_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr) |=> !(smi_pulse || sci_set || sci_clr));

  // R3
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr) |=> $stable(stat_q));

endmodule

// File: tb/apm_cmd_port_tb_top.sv
module apm_cmd_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic [7:0] smi_cfg = '0;
  logic       sci_set, sci_clr, smi_pulse;

  int n_chk = 0, n_bad = 0;
  logic [7:0] m_cmd = '0, m_stat = '0;

  always #10 clk = ~clk;

  apm_cmd_port dut_i (.clk, .rst_n, .wr_en, .addr, .wr_data, .rd_data,
                      .smi_cfg, .sci_set, .sci_clr, .smi_pulse);

  // {addr, data, cfg, exp_set, exp_clr, exp_smi}
  localparam logic [19:0] VEC [8] = '{
    {1'b0, 8'hF1, 8'h02, 3'b101},
    {1'b0, 8'hF0, 8'h00, 3'b010},
    {1'b0, 8'h5A, 8'h02, 3'b001},
    {1'b1, 8'hF1, 8'h02, 3'b000},
    {1'b0, 8'hF1, 8'hFD, 3'b100},
    {1'b1, 8'hF0, 8'hFF, 3'b000},
    {1'b0, 8'h00, 8'h02, 3'b001},
    {1'b0, 8'hF2, 8'h00, 3'b000}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic outs(input string req, input logic [2:0] exp);
    chk(req, {5'b0, sci_set, sci_clr, smi_pulse}, {5'b0, exp});
  endtask

  task automatic wr(input logic a, input logic [7:0] d, input logic [7:0] c);
    @(negedge clk);
    addr = a; wr_data = d; smi_cfg = c; wr_en = 1'b1;
    if (a) m_stat = d; else m_cmd = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    addr = 1'b0; #1 chk("R1 cmd reset", rd_data, 8'h00);
    addr = 1'b1; #1 chk("R1 stat reset", rd_data, 8'h00);
    outs("R1 outputs reset", 3'b000);

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][19], VEC[i][18:11], VEC[i][10:3]);
      outs($sformatf("R4/R5/R6/R7/R8 vec%0d strobes", i), VEC[i][2:0]);
      addr = 1'b0; #1 chk($sformatf("R2 vec%0d cmd readback", i), rd_data, m_cmd);
      addr = 1'b1; #1 chk($sformatf("R3 vec%0d stat readback", i), rd_data, m_stat);
      @(negedge clk);
      outs($sformatf("R4/R5/R7 vec%0d single cycle", i), 3'b000);
    end

    // R9 back-to-back set then clear
    @(negedge clk);
    addr = 1'b0; smi_cfg = 8'h00; wr_data = 8'hF1; wr_en = 1'b1;
    @(negedge clk);
    wr_data = 8'hF0;
    outs("R9 first of pair", 3'b100);
    @(negedge clk);
    wr_en = 1'b0;
    outs("R9 second of pair", 3'b010);
    @(negedge clk);
    outs("R9 after pair", 3'b000);

    // R1 reset after activity
    wr(1'b0, 8'hF1, 8'h02);
    wr(1'b1, 8'hA5, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    addr = 1'b0; #1 chk("R1 cmd re-reset", rd_data, 8'h00);
    addr = 1'b1; #1 chk("R1 stat re-reset", rd_data, 8'h00);
    outs("R1 outputs re-reset", 3'b000);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule